// File: doc/BRIEF.md
# Six-Channel DMA Controller

This block moves 16-bit words between memory and I/O, or from one memory location to another, without the processor taking part. Each of its six channels holds a source address, a destination address, a transfer count and a mode word. Software programs these through a narrow write port. A peripheral then raises that channel's request line. A fixed-priority arbiter picks the lowest-numbered channel that is both enabled and requesting. The sequencer then issues word transfers on a request/acknowledge bus port and returns an acknowledge line to the winning peripheral.

Four modes are available. In single mode a grant covers exactly one transfer. In block mode a grant runs to the end of the count. In demand mode transfers continue for as long as the request stays high. In cascade mode the channel does no transfers of its own and passes bus ownership to an external master. When a channel's last word completes, the controller pulses terminal count, disables the channel and raises a sticky completion flag.

Top module: `dmac_core`

## Requirements
- R1: Channels are numbered 0 to 5 and channel 0 has the highest priority. A grant is only decided while no transfer or cascade is in progress. The granted channel, and only that channel, sees its `dack` bit high.
- R2: A write with `cfg_field` 0 loads the source address, 1 the destination address, 2 the count (low 16 bits) and 3 the mode word. The mode word is laid out as bit 0 enable, bits 2:1 mode and bits 4:3 direction. Writing the mode word with enable set clears that channel's `done` flag.
- R3: `xfer_valid` rises one clock after a grant decision. While `bus_ack` is low, `xfer_valid`, `xfer_src`, `xfer_dst` and `xfer_dir` hold steady. `xfer_valid` drops in the clock after the acknowledge, so at most one word moves every two clocks.
- R4: Each acknowledged transfer adds 2 to both addresses and subtracts 1 from the count. A count of N gives N+1 transfers.
- R5: The transfer acknowledged while the count is 0 is the last one. It causes a one-clock `tc` pulse, clears the channel's enable and sets its `done` flag, so any further requests on that channel are ignored.
- R6: Mode 0 (single) performs one transfer per grant and then returns to arbitration.
- R7: Mode 1 (block) keeps transferring until the last transfer, whatever `dreq` does after the grant.
- R8: Mode 2 (demand) stops after the current transfer once `dreq` is low. A later grant resumes from the updated addresses and count.
- R9: Mode 3 (cascade) holds `ext_hold` and `dack` high while `dreq` stays high. It issues no transfers and does not change the count or the `done` flag.
- R10: `xfer_dir` carries the channel's direction code for every transfer: 0 memory to memory, 1 memory to I/O, 2 I/O to memory.
- R11: Synchronous reset clears every output to 0 and every channel's registers.
- R12: A request on a channel whose enable is 0 is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel selected for the write |
| cfg_field | input | 2 | Register selected: 0 source, 1 destination, 2 count, 3 mode |
| cfg_wdata | input | 26 | Write data |
| dreq | input | 6 | Per-channel transfer request |
| dack | output | 6 | Per-channel grant acknowledge |
| xfer_valid | output | 1 | Bus transfer request |
| xfer_src | output | 26 | Source byte address of the transfer |
| xfer_dst | output | 26 | Destination byte address of the transfer |
| xfer_dir | output | 2 | Direction code of the transfer |
| bus_ack | input | 1 | Bus completes the pending transfer |
| ext_hold | output | 1 | Bus handed to an external master (cascade) |
| tc | output | 6 | One-clock terminal count pulse per channel |
| done | output | 6 | Sticky completion flag per channel |

## Verification
The assertions rely on three things about the inputs. `bus_ack` is asserted only while `xfer_valid` is high. A channel is never reprogrammed while it owns the bus. A cascade channel drops its request only to end the hand-off. The bench meets these rules in the following way. It derives `bus_ack` at each falling edge from the current `xfer_valid`, gated by a pseudo-random stall. It performs configuration writes only between scenarios, once every channel has gone quiet.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    XM_SINGLE  = 2'd0,
    XM_BLOCK   = 2'd1,
    XM_DEMAND  = 2'd2,
    XM_CASCADE = 2'd3
  } xmode_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_XFER = 2'd1,
    S_GAP  = 2'd2,
    S_CASC = 2'd3
  } seq_state_t;

  localparam logic [1:0] FLD_SRC  = 2'd0;
  localparam logic [1:0] FLD_DST  = 2'd1;
  localparam logic [1:0] FLD_CNT  = 2'd2;
  localparam logic [1:0] FLD_MODE = 2'd3;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int CNT_W  = 16,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_field,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              step,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic              last,
  output logic              enable,
  output xmode_t            mode,
  output logic [1:0]        dir,
  output logic              done,
  output logic              tc
);
  logic [CNT_W-1:0] count;

  assign last = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      src    <= '0;
      dst    <= '0;
      count  <= '0;
      enable <= 1'b0;
      mode   <= XM_SINGLE;
      dir    <= 2'd0;
      done   <= 1'b0;
      tc     <= 1'b0;
    end else begin
      tc <= 1'b0;
      if (wr_en) begin
        case (wr_field)
          FLD_SRC: src   <= wr_data;
          FLD_DST: dst   <= wr_data;
          FLD_CNT: count <= wr_data[CNT_W-1:0];
          default: begin
            enable <= wr_data[0];
            mode   <= xmode_t'(wr_data[2:1]);
            dir    <= wr_data[4:3];
            if (wr_data[0]) done <= 1'b0;
          end
        endcase
      end else if (step) begin
        src   <= src + ADDR_W'(BYTES);
        dst   <= dst + ADDR_W'(BYTES);
        count <= count - CNT_W'(1);
        if (last) begin
          tc     <= 1'b1;
          enable <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dmac_arb.sv
module dmac_arb #(
  parameter int N    = 6,
  parameter int CH_W = 3
) (
  input  logic [N-1:0]    req,
  output logic [N-1:0]    gnt,
  output logic [CH_W-1:0] gnt_idx,
  output logic            any
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pri
    assign gnt[i]    = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[N];

  always_comb begin
    gnt_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt_idx = CH_W'(i);
    end
  end
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int N      = 6,
  parameter int CH_W   = 3,
  parameter int ADDR_W = 26
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N-1:0]               dreq,
  input  logic [N-1:0]               gnt,
  input  logic [CH_W-1:0]            gnt_idx,
  input  logic                       any,
  input  logic [N-1:0][ADDR_W-1:0]   src_a,
  input  logic [N-1:0][ADDR_W-1:0]   dst_a,
  input  xmode_t [N-1:0]             mode_a,
  input  logic [N-1:0][1:0]          dir_a,
  input  logic [N-1:0]               last_a,
  input  logic                       bus_ack,
  output logic [N-1:0]               step,
  output logic [N-1:0]               dack,
  output logic                       xfer_valid,
  output logic [ADDR_W-1:0]          xfer_src,
  output logic [ADDR_W-1:0]          xfer_dst,
  output logic [1:0]                 xfer_dir,
  output logic                       ext_hold,
  output logic                       idle
);
  seq_state_t      st;
  logic [CH_W-1:0] cur;

  assign idle = (st == S_IDLE);

  for (genvar i = 0; i < N; i++) begin : g_step
    assign step[i] = (st == S_XFER) && bus_ack && (cur == CH_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cur        <= '0;
      dack       <= '0;
      xfer_valid <= 1'b0;
      xfer_src   <= '0;
      xfer_dst   <= '0;
      xfer_dir   <= 2'd0;
      ext_hold   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (any) begin
            cur  <= gnt_idx;
            dack <= gnt;
            if (mode_a[gnt_idx] == XM_CASCADE) begin
              st       <= S_CASC;
              ext_hold <= 1'b1;
            end else begin
              st         <= S_XFER;
              xfer_valid <= 1'b1;
              xfer_src   <= src_a[gnt_idx];
              xfer_dst   <= dst_a[gnt_idx];
              xfer_dir   <= dir_a[gnt_idx];
            end
          end
        end
        S_XFER: begin
          if (bus_ack) begin
            xfer_valid <= 1'b0;
            if (last_a[cur] || mode_a[cur] == XM_SINGLE) begin
              st   <= S_IDLE;
              dack <= '0;
            end else begin
              st <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (mode_a[cur] == XM_DEMAND && !dreq[cur]) begin
            st   <= S_IDLE;
            dack <= '0;
          end else begin
            st         <= S_XFER;
            xfer_valid <= 1'b1;
            xfer_src   <= src_a[cur];
            xfer_dst   <= dst_a[cur];
            xfer_dir   <= dir_a[cur];
          end
        end
        default: begin
          if (!dreq[cur]) begin
            st       <= S_IDLE;
            dack     <= '0;
            ext_hold <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dmac_core.sv
module dmac_core
  import dmac_pkg::*;
#(
  parameter int N_CH   = 6,
  parameter int ADDR_W = 26,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [$clog2(N_CH)-1:0]  cfg_ch,
  input  logic [1:0]               cfg_field,
  input  logic [ADDR_W-1:0]        cfg_wdata,
  input  logic [N_CH-1:0]          dreq,
  output logic [N_CH-1:0]          dack,
  output logic                     xfer_valid,
  output logic [ADDR_W-1:0]        xfer_src,
  output logic [ADDR_W-1:0]        xfer_dst,
  output logic [1:0]               xfer_dir,
  input  logic                     bus_ack,
  output logic                     ext_hold,
  output logic [N_CH-1:0]          tc,
  output logic [N_CH-1:0]          done
);
  localparam int CH_W  = $clog2(N_CH);
  localparam int BYTES = DATA_W / 8;

  logic [N_CH-1:0][ADDR_W-1:0] src_a;
  logic [N_CH-1:0][ADDR_W-1:0] dst_a;
  xmode_t [N_CH-1:0]           mode_a;
  logic [N_CH-1:0][1:0]        dir_a;
  logic [N_CH-1:0]             last_a;
  logic [N_CH-1:0]             en_a;
  logic [N_CH-1:0]             step;
  logic [N_CH-1:0]             req;
  logic [N_CH-1:0]             gnt;
  logic [CH_W-1:0]             gnt_idx;
  logic                        any;
  logic                        idle;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    dmac_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BYTES(BYTES)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_we && (cfg_ch == CH_W'(i))),
      .wr_field(cfg_field),
      .wr_data (cfg_wdata),
      .step    (step[i]),
      .src     (src_a[i]),
      .dst     (dst_a[i]),
      .last    (last_a[i]),
      .enable  (en_a[i]),
      .mode    (mode_a[i]),
      .dir     (dir_a[i]),
      .done    (done[i]),
      .tc      (tc[i])
    );
  end

  assign req = (en_a & dreq) & {N_CH{idle}};

  dmac_arb #(.N(N_CH), .CH_W(CH_W)) u_arb (
    .req    (req),
    .gnt    (gnt),
    .gnt_idx(gnt_idx),
    .any    (any)
  );

  dmac_seq #(.N(N_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .dreq      (dreq),
    .gnt       (gnt),
    .gnt_idx   (gnt_idx),
    .any       (any),
    .src_a     (src_a),
    .dst_a     (dst_a),
    .mode_a    (mode_a),
    .dir_a     (dir_a),
    .last_a    (last_a),
    .bus_ack   (bus_ack),
    .step      (step),
    .dack      (dack),
    .xfer_valid(xfer_valid),
    .xfer_src  (xfer_src),
    .xfer_dst  (xfer_dst),
    .xfer_dir  (xfer_dir),
    .ext_hold  (ext_hold),
    .idle      (idle)
  );
endmodule

// File: rtl/dmac_core_chk.sv
module dmac_core_chk #(
  parameter int N_CH   = 6,
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst,
  input logic [N_CH-1:0]   dack,
  input logic              xfer_valid,
  input logic [ADDR_W-1:0] xfer_src,
  input logic [ADDR_W-1:0] xfer_dst,
  input logic [1:0]        xfer_dir,
  input logic              bus_ack,
  input logic              ext_hold,
  input logic [N_CH-1:0]   tc,
  input logic [N_CH-1:0]   done
);
  // R1
  dack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dack));

  // R3
  xfer_owner_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> $countones(dack) == 1);

  // R3
  xfer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !bus_ack) |=> (xfer_valid && $stable(xfer_src)
                                  && $stable(xfer_dst) && $stable(xfer_dir)));

  // R3
  xfer_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && bus_ack) |=> !xfer_valid);

  // R5
  tc_done_chk: assert property (@(posedge clk) disable iff (rst)
    (|tc) |-> ($onehot0(tc) && ((tc & done) == tc)));

  // R5
  tc_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (|tc) |-> $past(xfer_valid && bus_ack));

  // R9
  cascade_chk: assert property (@(posedge clk) disable iff (rst)
    ext_hold |-> (!xfer_valid && $countones(dack) == 1));

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!xfer_valid && dack == '0 && !ext_hold && tc == '0 && done == '0));
endmodule

bind dmac_core dmac_core_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dack      (dack),
  .xfer_valid(xfer_valid),
  .xfer_src  (xfer_src),
  .xfer_dst  (xfer_dst),
  .xfer_dir  (xfer_dir),
  .bus_ack   (bus_ack),
  .ext_hold  (ext_hold),
  .tc        (tc),
  .done      (done)
);

// File: tb/tb_dmac_core.sv
`timescale 1ns/1ps
module tb_dmac_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_ch = '0;
  logic [1:0]  cfg_field = '0;
  logic [25:0] cfg_wdata = '0;
  logic [5:0]  dreq = '0;
  logic [5:0]  dack;
  logic        xfer_valid;
  logic [25:0] xfer_src, xfer_dst;
  logic [1:0]  xfer_dir;
  logic        bus_ack = 1'b0;
  logic        ext_hold;
  logic [5:0]  tc, done;

  int checks = 0;
  int failures = 0;
  int nx [6] = '{default: 0};
  logic [7:0] lfsr = 8'h5A;

  always #2 clk = ~clk;

  dmac_core dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .dreq(dreq),
    .dack(dack), .xfer_valid(xfer_valid), .xfer_src(xfer_src),
    .xfer_dst(xfer_dst), .xfer_dir(xfer_dir), .bus_ack(bus_ack),
    .ext_hold(ext_hold), .tc(tc), .done(done)
  );

  // Behavioural reference model
  logic [25:0] m_src [6];
  logic [25:0] m_dst [6];
  logic [15:0] m_cnt [6];
  bit          m_en  [6];
  int          m_mode[6];
  int          m_dir [6];
  int          m_st;   // 0 idle, 1 moving, 2 between words, 3 handed off
  int          m_ch;
  bit          e_valid, e_hold;
  logic [25:0] e_src, e_dst;
  logic [1:0]  e_dir;
  logic [5:0]  e_dack, e_tc, e_done;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 6; i++) begin
        m_src[i] = 0; m_dst[i] = 0; m_cnt[i] = 0;
        m_en[i] = 0; m_mode[i] = 0; m_dir[i] = 0;
      end
      m_st = 0; m_ch = 0; e_valid = 0; e_hold = 0;
      e_src = 0; e_dst = 0; e_dir = 0;
      e_dack = 0; e_tc = 0; e_done = 0;
    end else begin
      e_tc = 0;
      case (m_st)
        0: begin
          int w;
          w = -1;
          for (int i = 5; i >= 0; i--) if (m_en[i] && dreq[i]) w = i;
          if (w >= 0) begin
            m_ch = w;
            e_dack = 6'(1 << w);
            if (m_mode[w] == 3) begin
              m_st = 3; e_hold = 1;
            end else begin
              m_st = 1; e_valid = 1;
              e_src = m_src[w]; e_dst = m_dst[w]; e_dir = 2'(m_dir[w]);
            end
          end
        end
        1: begin
          if (bus_ack) begin
            bit fin;
            fin = (m_cnt[m_ch] == 0);
            e_valid = 0;
            m_src[m_ch] = m_src[m_ch] + 2;
            m_dst[m_ch] = m_dst[m_ch] + 2;
            m_cnt[m_ch] = m_cnt[m_ch] - 1;
            if (fin) begin
              e_tc[m_ch] = 1; m_en[m_ch] = 0; e_done[m_ch] = 1;
            end
            if (fin || m_mode[m_ch] == 0) begin
              m_st = 0; e_dack = 0;
            end else m_st = 2;
          end
        end
        2: begin
          if (m_mode[m_ch] == 2 && !dreq[m_ch]) begin
            m_st = 0; e_dack = 0;
          end else begin
            m_st = 1; e_valid = 1;
            e_src = m_src[m_ch]; e_dst = m_dst[m_ch]; e_dir = 2'(m_dir[m_ch]);
          end
        end
        default: begin
          if (!dreq[m_ch]) begin
            m_st = 0; e_dack = 0; e_hold = 0;
          end
        end
      endcase
      if (cfg_we) begin
        case (cfg_field)
          2'd0: m_src[cfg_ch] = cfg_wdata;
          2'd1: m_dst[cfg_ch] = cfg_wdata;
          2'd2: m_cnt[cfg_ch] = cfg_wdata[15:0];
          default: begin
            m_en[cfg_ch]   = cfg_wdata[0];
            m_mode[cfg_ch] = int'(cfg_wdata[2:1]);
            m_dir[cfg_ch]  = int'(cfg_wdata[4:3]);
            if (cfg_wdata[0]) e_done[cfg_ch] = 0;
          end
        endcase
      end
    end
  end

  // Completed transfers per channel, seen at the port
  always @(posedge clk) begin
    if (!rst && xfer_valid && bus_ack) begin
      for (int i = 0; i < 6; i++) if (dack[i]) nx[i]++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison, then the bus acknowledge for the next edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R6 xfer_valid", 32'(xfer_valid), 32'(e_valid));
      if (e_valid) begin
        chk("R4 xfer_src", 32'(xfer_src), 32'(e_src));
        chk("R4 xfer_dst", 32'(xfer_dst), 32'(e_dst));
        chk("R10 xfer_dir", 32'(xfer_dir), 32'(e_dir));
      end
      chk("R1 dack", 32'(dack), 32'(e_dack));
      chk("R9 ext_hold", 32'(ext_hold), 32'(e_hold));
      chk("R5 tc", 32'(tc), 32'(e_tc));
      chk("R5 done", 32'(done), 32'(e_done));
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bus_ack = xfer_valid && !(lfsr[0] && lfsr[2]);
  end

  task automatic cfg(input int ch, input int fld, input logic [25:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 3'(ch); cfg_field = 2'(fld); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic prog(input int ch, input logic [25:0] s, input logic [25:0] d,
                      input int cnt, input logic [25:0] mw);
    cfg(ch, 0, s);
    cfg(ch, 1, d);
    cfg(ch, 2, 26'(cnt));
    cfg(ch, 3, mw);
  endtask

  task automatic wait_done(input int ch);
    while (!done[ch]) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11 reset outputs", {xfer_valid, ext_hold, dack, tc, done}, 0);

    // R6 single mode, direction 1, count 2 -> 3 transfers, dreq held throughout
    prog(2, 26'h0001000, 26'h3F00000, 2, 26'h09);
    dreq[2] = 1;
    wait_done(2);
    repeat (10) @(negedge clk);
    chk("R6 single transfers", 32'(nx[2]), 3);
    chk("R5 no transfer after terminal count", 32'(dack), 0);
    dreq[2] = 0;
    repeat (3) @(negedge clk);

    // R7 block mode, direction 2, one-cycle request, count 4 -> 5 transfers
    prog(1, 26'h0200000, 26'h0000400, 4, 26'h13);
    dreq[1] = 1;
    while (!dack[1]) @(negedge clk);
    dreq[1] = 0;
    chk("R10 block dir", 32'(xfer_dir), 2);
    chk("R2 block first src", 32'(xfer_src), 32'h0200000);
    wait_done(1);
    chk("R7 block transfers", 32'(nx[1]), 5);
    repeat (3) @(negedge clk);

    // R8 demand mode, count 5 -> 6 transfers, paused after 2
    prog(3, 26'h0100000, 26'h0180000, 5, 26'h05);
    dreq[3] = 1;
    while (nx[3] < 2) @(negedge clk);
    dreq[3] = 0;
    repeat (10) @(negedge clk);
    chk("R8 demand paused count", 32'(nx[3]), 2);
    chk("R8 demand not done", 32'(done[3]), 0);
    dreq[3] = 1;
    while (!(xfer_valid && dack[3])) @(negedge clk);
    chk("R4 demand resume src", 32'(xfer_src), 32'h0100004);
    chk("R4 demand resume dst", 32'(xfer_dst), 32'h0180004);
    wait_done(3);
    chk("R8 demand transfers", 32'(nx[3]), 6);
    dreq[3] = 0;
    repeat (3) @(negedge clk);

    // R1 priority: channel 0 beats channel 4
    prog(0, 26'h0000010, 26'h0000800, 1, 26'h01);
    prog(4, 26'h0000020, 26'h0000900, 0, 26'h11);
    dreq[0] = 1; dreq[4] = 1;
    @(negedge clk);
    chk("R1 lowest channel wins", 32'(dack), 32'h01);
    wait_done(0);
    dreq[0] = 0;
    wait_done(4);
    dreq[4] = 0;
    chk("R1 ch0 transfers", 32'(nx[0]), 2);
    chk("R1 ch4 transfers", 32'(nx[4]), 1);
    repeat (3) @(negedge clk);

    // R9 cascade hand-off
    prog(5, 26'h0000000, 26'h0000000, 3, 26'h07);
    dreq[5] = 1;
    repeat (12) @(negedge clk);
    chk("R9 cascade hold", 32'(ext_hold), 1);
    chk("R9 cascade dack", 32'(dack), 32'h20);
    dreq[5] = 0;
    repeat (2) @(negedge clk);
    chk("R9 cascade released", 32'(ext_hold), 0);
    chk("R9 cascade no transfers", 32'(nx[5]), 0);
    chk("R9 cascade not done", 32'(done[5]), 0);

    // R12 disabled channel ignored
    cfg(4, 3, 26'h10);
    dreq[4] = 1;
    repeat (8) @(negedge clk);
    chk("R12 disabled dack", 32'(dack), 0);
    chk("R12 disabled transfers", 32'(nx[4]), 1);
    dreq[4] = 0;

    // R2 re-enable clears done
    chk("R2 done before re-enable", 32'(done[4]), 1);
    cfg(4, 3, 26'h11);
    @(negedge clk);
    chk("R2 done cleared", 32'(done[4]), 0);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule